// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block derives the SD card clock from a base clock. Software sets it through one 16-bit control word on a simple write port, and the same word reads back on `rd_data`. A 10-bit divider code selects the card clock frequency. Code 0 passes the base clock straight through. Any other code N gives a clock of base/(2N) with an even split between high and low time.

Start-up has two steps. Software first sets the internal enable. A stable flag then rises after a fixed settling count. The card clock gate opens only after that flag is up and the card enable is set. The gate opens and closes only while the selected clock source is low, so the card never sees a shortened pulse.

To change the frequency, software clears the card enable and waits for the gate to close. It then writes the new code. The block refuses to stop the card clock while the command line or the data line reports busy.

Top module: `sd_clk_divctl`

## Requirements
- R1: Control word layout: bit 0 is the internal enable, bit 1 is the stable flag (read-only, write ignored), bit 2 is the card enable, and bits 5:3 always read 0. Divider code bits 9:8 sit in word bits 7:6, and code bits 7:0 sit in word bits 15:8. A write updates the word seen on `rd_data` one clock later.
- R2: With code 0, the enabled card clock equals the base clock: its period is one base period.
- R3: With code N>0, the enabled card clock has a period of 2N base cycles and a high time of N base cycles.
- R4: The stable flag rises exactly STABLE_CYCLES clocks after the write edge that sets the internal enable. It reads 0 in the cycle after the internal enable reads 0. It is never 1 while the internal enable is 0.
- R5: An accepted write that changes the divider code while the internal enable is set restarts the settling count. The stable flag drops and rises again STABLE_CYCLES clocks after that write.
- R6: The card clock gate opens only when the card enable and the stable flag are both set. A card enable written before the clock is stable leaves the card clock low until the flag rises.
- R7: The gate (`card_clk_on`) changes only at a falling base-clock edge while the divided source is low, so no runt pulse reaches `card_clk`.
- R8: A write that clears the card enable while `cmd_busy` or `dat_busy` is high is refused. The card enable stays 1 and the card clock keeps running.
- R9: Divider code fields of a write are ignored while the card enable reads 1 or the gate is still open.
- R10: After the card enable is cleared with both busy inputs low, the gate closes within one divided period, and `card_clk` then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word |
| cmd_busy | input | 1 | Command line in use |
| dat_busy | input | 1 | Data line in use |
| card_clk | output | 1 | Gated card clock |
| int_stable | output | 1 | Internal clock settled |
| card_clk_on | output | 1 | Card clock gate state |

## Verification
The assertions assume that `wr_en`, `wr_data` and both busy inputs change only away from the rising base-clock edge. They also assume that software waits for `card_clk_on` to fall before it writes a new code. The gate checks further assume that `div_q` is still only between rising edges. The bench drives every input at falling edges and samples just after rising edges. Before each code change it polls the gate closed. It sweeps codes 0, 1, 2, 3, 255, 256, 511 and 1023, each distinct from the one before, so every code change restarts the settling count.

// File: rtl/sd_clk_divctl.sv
module sd_clk_divctl #(
  parameter int CODE_W        = 10,
  parameter int STABLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        cmd_busy,
  input  logic        dat_busy,
  output logic        card_clk,
  output logic        int_stable,
  output logic        card_clk_on
);
  localparam int SCNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [SCNT_W-1:0] SCNT_MAX = SCNT_W'(STABLE_CYCLES);

  logic              int_en_q, card_en_q, gate_q, div_q;
  logic [CODE_W-1:0] code_q, dcnt_q, wr_code;
  logic [SCNT_W-1:0] scnt_q;
  logic              busy, code_ok, code_wr, code_zero, want;

  assign busy      = cmd_busy | dat_busy;
  assign wr_code   = CODE_W'({wr_data[7:6], wr_data[15:8]});
  assign code_ok   = !card_en_q && !gate_q;
  assign code_wr   = wr_en && code_ok && (wr_code != code_q);
  assign code_zero = (code_q == '0);
  assign int_stable = int_en_q && (scnt_q == SCNT_MAX);
  assign want      = card_en_q && int_stable;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_en_q  <= 1'b0;
      card_en_q <= 1'b0;
      code_q    <= '0;
    end else if (wr_en) begin
      int_en_q  <= wr_data[0];
      card_en_q <= wr_data[2] | (card_en_q & busy);
      if (code_ok) code_q <= wr_code;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  scnt_q <= '0;
    else if (!int_en_q || code_wr) scnt_q <= '0;
    else if (scnt_q != SCNT_MAX) scnt_q <= scnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt_q <= '0;
      div_q  <= 1'b0;
    end else if (!int_en_q || code_zero || code_wr) begin
      dcnt_q <= '0;
      div_q  <= 1'b0;
    end else if (dcnt_q == code_q - 1'b1) begin
      dcnt_q <= '0;
      div_q  <= ~div_q;
    end else begin
      dcnt_q <= dcnt_q + 1'b1;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)      gate_q <= 1'b0;
    else if (!div_q) gate_q <= want;

  assign card_clk    = gate_q & (code_zero ? clk : div_q);
  assign card_clk_on = gate_q;
  assign rd_data     = {code_q[7:0], code_q[9:8], 3'b000, card_en_q, int_stable, int_en_q};
endmodule

// File: rtl/sd_clk_divctl_chk.sv
module sd_clk_divctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        cmd_busy,
  input logic        dat_busy,
  input logic        int_stable,
  input logic        card_clk_on,
  input logic        src_q
);
  AST_GATE_SRC_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    (card_clk_on != $past(card_clk_on)) |-> !$past(src_q)); // R7

  AST_GATE_NEEDS_STABLE: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(card_clk_on) |-> $past(int_stable && rd_data[2])); // R6

  AST_STOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && rd_data[2] && (cmd_busy || dat_busy)) |=> rd_data[2]); // R8

  AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (rd_data[2] || card_clk_on)) |=> (rd_data[15:6] == $past(rd_data[15:6]))); // R9

  AST_STABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !int_stable); // R4

  AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    int_stable |-> rd_data[0]); // R4
endmodule

bind sd_clk_divctl sd_clk_divctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .cmd_busy(cmd_busy), .dat_busy(dat_busy),
  .int_stable(int_stable), .card_clk_on(card_clk_on), .src_q(div_q)
);

// File: tb/sd_clk_divctl_test.sv
module sd_clk_divctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmd_busy = 1'b0, dat_busy = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        card_clk, int_stable, card_clk_on;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_clk_divctl #(.CODE_W(10), .STABLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_busy(cmd_busy), .dat_busy(dat_busy), .card_clk(card_clk),
    .int_stable(int_stable), .card_clk_on(card_clk_on)
  );

  function automatic logic [15:0] word(input bit ie, input bit st, input bit ce, input int n);
    logic [9:0] c = 10'(n);
    return {c[7:0], c[9:8], 3'b000, ce, st, ie};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_closed(input int n);
    for (int i = 0; i < 2*n + 4 && card_clk_on; i++) tick(1);
    chk("R10 gate closed", card_clk_on, 0);
    begin
      int highs = 0;
      for (int i = 0; i < 2*n + 4; i++) begin
        @(negedge clk); if (card_clk) highs++;
        @(posedge clk); #1; if (card_clk) highs++;
      end
      chk("R10 card clock held low", highs, 0);
    end
  endtask

  task automatic run_code(input int n, input int prev, input bit first);
    realtime t1, t2, t3, tf;
    if (!first) begin
      wr(word(1, 0, 0, prev));
      wait_closed(prev);
    end
    wr(word(1, 0, 0, n));
    tick(SETTLE - 1);
    chk(first ? "R4 stable early" : "R5 stable early", int_stable, 0);
    tick(1);
    chk(first ? "R4 stable on time" : "R5 stable on time", int_stable, 1);
    chk("R1 readback", rd_data, word(1, 1, 0, n));
    wr(word(1, 0, 1, n));
    @(posedge card_clk); t1 = $realtime;
    @(posedge card_clk); t2 = $realtime;
    @(posedge card_clk); t3 = $realtime;
    @(negedge card_clk); tf = $realtime;
    if (n == 0) begin
      chk("R2 period", longint'(t2 - t1), CLK_PERIOD);
      chk("R2 period", longint'(t3 - t2), CLK_PERIOD);
    end else begin
      chk("R3 period", longint'(t2 - t1), 2*n*CLK_PERIOD);
      chk("R3 period", longint'(t3 - t2), 2*n*CLK_PERIOD);
      chk("R3 high time", longint'(tf - t3), n*CLK_PERIOD);
    end
    #1;
    chk("R6 gate open", card_clk_on, 1);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int codes[8] = '{0, 1, 2, 3, 255, 256, 511, 1023};
    tick(3);
    chk("R1 reset word", rd_data, 0);
    chk("R6 reset gate", card_clk_on, 0);
    chk("R6 reset clock", card_clk, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);

    wr(16'h003A);
    chk("R1 read-only and zero bits", rd_data, word(0, 0, 0, 0));
    wr(word(0, 0, 0, 'h2C5));
    chk("R1 split code field", rd_data, 16'hC580);
    wr(word(0, 0, 0, 0));

    for (int i = 0; i < 8; i++)
      run_code(codes[i], (i == 0) ? 0 : codes[i-1], i == 0);

    wr(word(1, 0, 1, 3));
    chk("R9 code locked while on", rd_data, word(1, 1, 1, 1023));
    wr(word(0, 0, 0, 1023));
    chk("R4 stable drops", int_stable, 0);
    wait_closed(1023);
    wr(word(1, 0, 0, 3));
    tick(SETTLE);
    wr(word(1, 0, 1, 3));
    tick(4);

    @(negedge clk); cmd_busy = 1'b1;
    wr(word(1, 0, 0, 3));
    tick(SETTLE);
    chk("R8 cmd busy keeps enable", rd_data[2], 1);
    chk("R8 cmd busy keeps gate", card_clk_on, 1);
    @(negedge clk); cmd_busy = 1'b0; dat_busy = 1'b1;
    wr(word(1, 0, 0, 3));
    tick(SETTLE);
    chk("R8 dat busy keeps enable", rd_data[2], 1);
    chk("R8 dat busy keeps gate", card_clk_on, 1);
    @(negedge clk); dat_busy = 1'b0;
    wr(word(1, 0, 0, 3));
    chk("R10 enable cleared", rd_data[2], 0);
    wait_closed(3);

    wr(word(0, 0, 0, 3));
    wr(word(1, 0, 1, 5));
    tick(4);
    chk("R6 enable before stable", rd_data, word(1, 0, 1, 5));
    chk("R6 gate waits for stable", card_clk_on, 0);
    tick(SETTLE - 4);
    chk("R4 stable after enable", int_stable, 1);
    tick(12);
    chk("R6 gate opens after stable", card_clk_on, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule